// File: doc/BRIEF.md
# Protection region register bank

This block is the register file of an eight-region memory protection unit. Software reaches it through a simple word-wide bus that carries a request, a write strobe, a two-bit word index and 32-bit data. The bank holds a control word, a region selector, and a base word and an attribute word for each region. The base and attribute words are windowed: an access to either one lands on whichever region the selector names.

A base-address write can retarget the selector while it writes. When its valid bit is set, the low nibble of the written data chooses the region. That region becomes current, and the same write stores its base. A single bus write therefore programs any region, without a separate selector write first.

The bank drives every region's base and enable bit, for use by the address-match logic elsewhere. It also drives one protection-active signal. That signal combines the global enable with the priority class the core is running at. Protection is dropped in the two negative-priority fault handlers unless a control bit keeps it on.

Top module: `mpu_region_bank`

## Requirements
- R1: After reset every register is zero. Region 0 is selected, every `region_en_o` bit is 0, every `region_base_o` word is 0, and `prot_active_o` is 0.
- R2: Word index 1 is the selector. A write stores `wdata_i[7:0]` only when that value is 0 to 7; a value of 8 or more leaves the selector unchanged. A read returns the selector in bits [7:0], with bits [31:8] zero.
- R3: A base or attribute write changes only the currently selected region, or the retargeted region under R4. Every other region keeps its base and attribute.
- R4: Word index 2 is the base register. A write to it with bit 4 = 1 and `wdata_i[3:0]` in the range 0 to 7 loads that value into the selector. In the same cycle it stores the written base into the newly selected region.
- R5: A base write with bit 4 = 1 and `wdata_i[3:0]` of 8 or more is ignored as a whole: the selector and all bases are unchanged.
- R6: A base write stores `wdata_i[31:BASE_LSB]` (BASE_LSB defaults to 8). A base read returns the stored address in bits [31:BASE_LSB], zero in bits [BASE_LSB-1:4] (bit 4, the valid bit, included), and the current selector in bits [3:0].
- R7: Word index 3 is the attribute register. It stores bits [31:8] and [5:0] of the written word; bits [7:6] read as zero. Bit 0 is the region enable, driven on `region_en_o[i]` for region i. `region_base_o[32*i +: 32]` carries region i's base with its low BASE_LSB bits zero.
- R8: Word index 0 is the control register. Bit 0 is the global enable and bit 1 is the keep-on-in-fault-handlers bit. All other bits are discarded on write and read as zero.
- R9: `pri_class_i` codes the priority class as 0 = thread, 1 = handler at priority 0 or above, 2 = priority -1, 3 = priority -2. `prot_active_o` = global enable AND NOT (`pri_class_i[1]` AND NOT keep-on bit). It is combinational from the registers and this input.
- R10: `rdata_o` is combinational. It carries the addressed word while `req_i`=1 and `we_i`=0, and is zero at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word index: 0 control, 1 selector, 2 base, 3 attribute |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| pri_class_i | input | 2 | Current priority class of the core |
| prot_active_o | output | 1 | Protection active |
| region_en_o | output | 8 | Per-region enable |
| region_base_o | output | 256 | Per-region base, region i in bits [32*i+31:32*i] |

## Verification
The hardest case to reach from the ports is a retargeting base write whose nibble is out of range, together with proof that no region was touched. To reach it, the random stimulus sets the valid bit on about half of its base writes and draws the nibble from the full 0 to 15 range, so both accepted and rejected retargets occur often. After every write the bench compares all eight base words and the enable vector against its model. A stray write to any region, not only the selected one, is therefore seen. Directed writes of selector values just above 7 cover the matching rejection on the selector register.

// File: rtl/mpu_bank_pkg.sv
package mpu_bank_pkg;
  localparam int unsigned NUM_REGIONS = 8;
  localparam int unsigned SEL_W       = $clog2(NUM_REGIONS);
  localparam int unsigned DATA_W      = 32;

  typedef enum logic [1:0] {
    OFS_CTRL = 2'd0,
    OFS_SEL  = 2'd1,
    OFS_BASE = 2'd2,
    OFS_ATTR = 2'd3
  } reg_ofs_e;

  // attribute bits kept: [31:8] and [5:0]
  localparam logic [DATA_W-1:0] ATTR_KEEP = 32'hFFFF_FF3F;
endpackage

// File: rtl/mpu_sel_reg.sv
module mpu_sel_reg
  import mpu_bank_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_we_i,
  input  logic [7:0]       sel_wdata_i,
  input  logic             rtg_we_i,
  input  logic [3:0]       rtg_wdata_i,
  output logic [SEL_W-1:0] sel_o
);
  logic sel_ok, rtg_ok;

  assign sel_ok = sel_we_i && (sel_wdata_i < 8'(NUM_REGIONS));
  assign rtg_ok = rtg_we_i && (rtg_wdata_i < 4'(NUM_REGIONS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_o <= '0;
    else if (rtg_ok) sel_o <= rtg_wdata_i[SEL_W-1:0];
    else if (sel_ok) sel_o <= sel_wdata_i[SEL_W-1:0];
  end
endmodule

// File: rtl/mpu_region_slot.sv
module mpu_region_slot
  import mpu_bank_pkg::*;
#(
  parameter int unsigned BASE_LSB = 8,
  localparam int unsigned HI_W    = DATA_W - BASE_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [HI_W-1:0]   base_wdata_i,
  input  logic              attr_we_i,
  input  logic [DATA_W-1:0] attr_wdata_i,
  output logic [HI_W-1:0]   base_o,
  output logic [DATA_W-1:0] attr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_o <= '0;
    else if (base_we_i) base_o <= base_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        attr_o <= '0;
    else if (attr_we_i) attr_o <= attr_wdata_i & ATTR_KEEP;
  end
endmodule

// File: rtl/mpu_ctrl_reg.sv
module mpu_ctrl_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  input  logic [1:0] pri_class_i,
  output logic       gen_en_o,
  output logic       hp_en_o,
  output logic       prot_active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_en_o <= 1'b0;
      hp_en_o  <= 1'b0;
    end else if (we_i) begin
      gen_en_o <= wdata_i[0];
      hp_en_o  <= wdata_i[1];
    end
  end

  // classes 2 and 3 are the negative-priority fault handlers
  assign prot_active_o = gen_en_o && !(pri_class_i[1] && !hp_en_o);
endmodule

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
  import mpu_bank_pkg::*;
#(
  parameter int unsigned BASE_LSB = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [1:0]                    addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [1:0]                    pri_class_i,
  output logic                          prot_active_o,
  output logic [NUM_REGIONS-1:0]        region_en_o,
  output logic [NUM_REGIONS*DATA_W-1:0] region_base_o
);
  localparam int unsigned HI_W = DATA_W - BASE_LSB;

  logic                   wr, rd;
  logic                   wr_ctrl, wr_sel, wr_base, wr_attr;
  logic                   rtg_req, base_ok;
  logic [SEL_W-1:0]       sel_q, tgt;
  logic                   gen_en_q, hp_en_q;
  logic [NUM_REGIONS-1:0] slot_base_we, slot_attr_we;
  logic [HI_W-1:0]        base_q [NUM_REGIONS];
  logic [DATA_W-1:0]      attr_q [NUM_REGIONS];

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign wr_ctrl = wr && (addr_i == OFS_CTRL);
  assign wr_sel  = wr && (addr_i == OFS_SEL);
  assign wr_base = wr && (addr_i == OFS_BASE);
  assign wr_attr = wr && (addr_i == OFS_ATTR);

  // valid bit set: region nibble retargets the selector
  assign rtg_req = wr_base && wdata_i[4];
  assign base_ok = wr_base && !(wdata_i[4] && (wdata_i[3:0] >= 4'(NUM_REGIONS)));
  assign tgt     = wdata_i[4] ? wdata_i[SEL_W-1:0] : sel_q;

  mpu_sel_reg u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_we_i    (wr_sel),
    .sel_wdata_i (wdata_i[7:0]),
    .rtg_we_i    (rtg_req),
    .rtg_wdata_i (wdata_i[3:0]),
    .sel_o       (sel_q)
  );

  mpu_ctrl_reg u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (wr_ctrl),
    .wdata_i       (wdata_i[1:0]),
    .pri_class_i   (pri_class_i),
    .gen_en_o      (gen_en_q),
    .hp_en_o       (hp_en_q),
    .prot_active_o (prot_active_o)
  );

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_slot
    assign slot_base_we[i] = base_ok && (tgt == SEL_W'(i));
    assign slot_attr_we[i] = wr_attr && (sel_q == SEL_W'(i));

    mpu_region_slot #(.BASE_LSB(BASE_LSB)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .base_we_i    (slot_base_we[i]),
      .base_wdata_i (wdata_i[DATA_W-1:BASE_LSB]),
      .attr_we_i    (slot_attr_we[i]),
      .attr_wdata_i (wdata_i),
      .base_o       (base_q[i]),
      .attr_o       (attr_q[i])
    );

    assign region_en_o[i]               = attr_q[i][0];
    assign region_base_o[i*DATA_W +: DATA_W] = {base_q[i], {BASE_LSB{1'b0}}};
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        OFS_CTRL: rdata_o = {{(DATA_W-2){1'b0}}, hp_en_q, gen_en_q};
        OFS_SEL:  rdata_o = {{(DATA_W-SEL_W){1'b0}}, sel_q};
        OFS_BASE: rdata_o = {base_q[sel_q], {(BASE_LSB-SEL_W){1'b0}}, sel_q};
        default:  rdata_o = attr_q[sel_q];
      endcase
    end
  end
endmodule

// File: rtl/mpu_region_bank_chk.sv
module mpu_region_bank_chk
  import mpu_bank_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_i,
  input logic                   we_i,
  input logic [1:0]             addr_i,
  input logic [DATA_W-1:0]      wdata_i,
  input logic [1:0]             pri_class_i,
  input logic                   prot_active_o,
  input logic [NUM_REGIONS-1:0] region_en_o,
  input logic [SEL_W-1:0]       sel_q,
  input logic                   hp_en_q,
  input logic [NUM_REGIONS-1:0] slot_base_we
);
  logic wr;
  assign wr = req_i && we_i;

  a_r2_sel_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == 2'd1 && wdata_i[7:0] > 8'd7) |=> $stable(sel_q));

  a_r4_retarget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == 2'd2 && wdata_i[4] && !wdata_i[3]) |=> (sel_q == $past(wdata_i[2:0])));

  a_r5_rtg_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == 2'd2 && wdata_i[4] && wdata_i[3]) |-> (slot_base_we == '0));

  a_r3_one_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_base_we));

  a_r7_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i == 2'd3) |=> $stable(region_en_o));

  a_r9_fault_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pri_class_i[1] && !hp_en_q) |-> !prot_active_o);
endmodule

bind mpu_region_bank mpu_region_bank_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .pri_class_i   (pri_class_i),
  .prot_active_o (prot_active_o),
  .region_en_o   (region_en_o),
  .sel_q         (sel_q),
  .hp_en_q       (hp_en_q),
  .slot_base_we  (slot_base_we)
);

// File: tb/mpu_region_bank_test.sv
`timescale 1ns/1ps
module mpu_region_bank_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0, we_i = 1'b0;
  logic [1:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [1:0]   pri_class_i = '0;
  logic         prot_active_o;
  logic [7:0]   region_en_o;
  logic [255:0] region_base_o;

  mpu_region_bank uut (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] m_base [8];
  logic [31:0] m_attr [8];
  logic [2:0]  m_sel;
  logic [1:0]  m_ctrl;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [1:0] a);
    case (a)
      2'd0: return {30'b0, m_ctrl};
      2'd1: return {29'b0, m_sel};
      2'd2: return m_base[m_sel] | {29'b0, m_sel};
      default: return m_attr[m_sel];
    endcase
  endfunction

  function automatic logic exp_prot(logic [1:0] pc);
    return m_ctrl[0] && !(pc[1] && !m_ctrl[1]);
  endfunction

  task automatic model_write(logic [1:0] a, logic [31:0] d);
    case (a)
      2'd0: m_ctrl = d[1:0];
      2'd1: if (d[7:0] < 8) m_sel = d[2:0];
      2'd2: begin
        if (!d[4]) m_base[m_sel] = d & 32'hFFFF_FF00;
        else if (d[3:0] < 8) begin
          m_sel = d[2:0];
          m_base[m_sel] = d & 32'hFFFF_FF00;
        end
      end
      default: m_attr[m_sel] = d & 32'hFFFF_FF3F;
    endcase
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    model_write(a, d);
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic bus_read(logic [1:0] a, string req);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    #1 chk(req, rdata_o, exp_read(a));
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic chk_outputs(string req);
    #1;
    for (int i = 0; i < 8; i++) begin
      chk(req, region_base_o[32*i +: 32], m_base[i]);
      chk(req, {31'b0, region_en_o[i]}, {31'b0, m_attr[i][0]});
    end
  endtask

  task automatic chk_prot(string req);
    for (int p = 0; p < 4; p++) begin
      pri_class_i = 2'(p);
      #1 chk(req, {31'b0, prot_active_o}, {31'b0, exp_prot(2'(p))});
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_attr[i] = 0; end
    m_sel = 0; m_ctrl = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", {31'b0, prot_active_o}, 32'h0);
    chk_outputs("R1");
    rst_ni = 1;
    for (int a = 0; a < 4; a++) bus_read(2'(a), "R1");

    // R2 selector accept and reject
    bus_write(2'd1, 32'hFFFF_FF05);
    bus_read(2'd1, "R2");
    chk("R2", {29'b0, m_sel}, 32'd5);
    bus_write(2'd1, 32'h0000_0008);
    bus_read(2'd1, "R2");
    bus_write(2'd1, 32'h0000_0103);
    bus_read(2'd1, "R2");
    bus_write(2'd1, 32'h0000_0005);

    // R6 plain base write with reserved bits set
    bus_write(2'd2, 32'hABCD_12EF & ~32'h10);
    bus_read(2'd2, "R6");
    chk("R6", exp_read(2'd2), 32'hABCD_1205);

    // R4 retarget to region 3, R3 region 5 untouched
    bus_write(2'd2, 32'h1234_5613);
    bus_read(2'd1, "R4");
    bus_read(2'd2, "R4");
    chk("R4", region_base_o[96 +: 32], 32'h1234_5600);
    chk("R3", region_base_o[160 +: 32], 32'hABCD_1200);

    // R5 retarget to region 12 ignored
    bus_write(2'd2, 32'hFFFF_FF1C);
    bus_read(2'd1, "R5");
    chk_outputs("R5");

    // R7 attributes
    bus_write(2'd3, 32'hFFFF_FFFF);
    bus_read(2'd3, "R7");
    chk_outputs("R7");

    // R8 and R9 control and protection
    bus_write(2'd0, 32'hFFFF_FFFC);
    bus_read(2'd0, "R8");
    chk_prot("R9");
    bus_write(2'd0, 32'h0000_0001);
    chk_prot("R9");
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, "R8");
    chk_prot("R9");

    // R10 idle and write cycles read zero
    @(negedge clk_i);
    req_i = 0; addr_i = 2'd3;
    #1 chk("R10", rdata_o, 32'h0);
    req_i = 1; we_i = 1; addr_i = 2'd1; wdata_i = 32'hFF;
    #1 chk("R10", rdata_o, 32'h0);
    req_i = 0; we_i = 0;

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [1:0]  a;
      logic [31:0] d;
      a = 2'($urandom_range(0, 3));
      d = $urandom;
      if (a == 2'd1) d[7:0] = 8'($urandom_range(0, 15));
      if (a == 2'd2) d[4] = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 2) == 0) bus_read(a, "R3 random read");
      else begin
        bus_write(a, d);
        chk_outputs("R3 random");
        pri_class_i = 2'($urandom_range(0, 3));
        #1 chk("R9 random", {31'b0, prot_active_o}, {31'b0, exp_prot(pri_class_i)});
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule